// File: doc/BRIEF.md
# Parking Bus Arbiter with Retry Hold-off

This block decides which master owns a shared split-transaction processor bus. A handful of external masters and one internal bridge master raise request lines, and the arbiter answers with a registered grant vector that has at most one bit set. The internal master always wins when it asks. The external masters take turns in round-robin order, and each external master can be switched off by its own enable bit.

When nothing is requested, the arbiter can optionally park the bus. It can leave the grant on the previous owner, or it can hand the bus to a programmed default master. Two protective modes act on external masters only. The first counts address tenures that are still waiting for their data tenure to finish, and it holds back external grants so that the bus is never pipelined more than one level deep. The second watches for address-retry cycles and shuts external masters out for a fixed window. The jitter this adds breaks live-lock between masters that keep retrying each other.

A single control register sets all of these options. It is written through a synchronous write port and can be read back at any time.

Top module: `bus_grant_arbiter`

## Requirements
- R1: After reset no grant is asserted, and the control register reads 0x40F for the default of four external masters. The bit layout, from the least significant bit up, is: bits 3:0 are the per-master enables, bit 4 is park-enable, bit 5 is park-mode (0 = last owner, 1 = default owner), bits 8:6 are the default owner, bit 9 is pipeline-limit and bit 10 is retry-hold.
- R2: When `cfg_we` is high at a clock edge, `cfg_wdata` is stored and reads back unchanged on `cfg_rdata` from the next cycle. The new value takes effect in the arbitration of the following edge.
- R3: A request from the internal master is granted (`gnt_host`) at the next grant update, ahead of any external request.
- R4: External requests are served in rotating order. The search starts at the index after the last external master granted on a request. After reset the search starts at index 0.
- R5: An external master whose enable bit is clear is never granted.
- R6: When parking is off and no request is eligible, no grant is asserted.
- R7: When parking is on in last-owner mode and no request is eligible, the most recent owner is granted again. After reset that owner is the internal master.
- R8: When parking is on in default mode, the owner is taken from the default-owner field. The value 4 (the master count) selects the internal master, and values 0 to 3 select an external master only if that master is enabled and not held off. Any other value parks on nobody.
- R9: When pipeline-limit is set, the arbiter counts address tenures begun (`addr_start`) against data tenures ended (`data_end`). An external master is granted only while that count is at most 1. The internal master is not affected.
- R10: When retry-hold is set, each `addr_retry` pulse bars new external grants for 8 cycles. A retry that arrives inside the window restarts it. The internal master can still be granted during the window. When retry-hold is clear, retries have no effect.
- R11: Grants are registered, at most one is high, and they do not change from the cycle after `addr_start` up to and including the cycle of `addr_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 11 | Control register write data |
| cfg_rdata | output | 11 | Control register read-back |
| req_ext | input | 4 | External master requests |
| req_host | input | 1 | Internal bridge master request |
| addr_start | input | 1 | Address tenure begins (pulse) |
| addr_end | input | 1 | Address tenure ends (pulse) |
| data_end | input | 1 | Data tenure ends (pulse) |
| addr_retry | input | 1 | Address-retry observed on the bus (pulse) |
| gnt_ext | output | 4 | One-hot grant to external masters |
| gnt_host | output | 1 | Grant to the internal master |

## Verification
The assertions assume that the bus strobes are well formed. `addr_start` appears only when no address tenure is open, `addr_end` appears only while one is open, and `data_end` never outnumbers the address tenures that were started. If these strobes were malformed, the freeze and pipeline-depth properties would be checking a bus that cannot exist. The random stimulus keeps to these rules by tracking open tenures and pending data in the bench model, and it pulses each strobe only when that pulse is legal. It keeps the pending count below the counter's limit, and it mixes in occasional retries, control writes and internal requests.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {PARK_LAST = 1'b0, PARK_DFLT = 1'b1} park_mode_e;

  function automatic int owner_width(input int n);
    return $clog2(n + 2);
  endfunction
endpackage

// File: rtl/arb_cfg_reg.sv
module arb_cfg_reg #(
  parameter int N_EXT = 4,
  parameter int DM_W  = 3,
  parameter int CFG_W = N_EXT + 4 + DM_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] q
);
  // reset: retry-hold on, pipeline-limit off, parking off, all enables on
  localparam logic [CFG_W-1:0] RST_VAL = {1'b1, 1'b0, {DM_W{1'b0}}, 1'b0, 1'b0, {N_EXT{1'b1}}};

  always_ff @(posedge clk) begin
    if (rst)     q <= RST_VAL;
    else if (we) q <= wdata;
  end

  AST_CFG_WRITE: assert property (@(posedge clk) disable iff (rst)
    we |=> (q == $past(wdata))); // R2
endmodule

// File: rtl/arb_tenure.sv
module arb_tenure #(
  parameter int PEND_W = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic addr_start,
  input  logic addr_end,
  input  logic data_end,
  output logic abusy,
  output logic pend_ok
);
  localparam logic [PEND_W-1:0] PMAX = {PEND_W{1'b1}};
  logic [PEND_W-1:0] pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      abusy <= 1'b0;
      pend  <= '0;
    end else begin
      if (addr_start)    abusy <= 1'b1;
      else if (addr_end) abusy <= 1'b0;
      case ({addr_start, data_end})
        2'b10:   if (pend != PMAX) pend <= pend + 1'b1;
        2'b01:   if (pend != '0)   pend <= pend - 1'b1;
        default: pend <= pend;
      endcase
    end
  end

  assign pend_ok = (pend <= 1);

  AST_PEND_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (pend == PMAX && addr_start && !data_end) |=> (pend == PMAX)); // R9
  AST_PEND_NO_UNDER: assert property (@(posedge clk) disable iff (rst)
    (pend == '0 && data_end && !addr_start) |=> (pend == '0)); // R9
endmodule

// File: rtl/arb_holdoff.sv
module arb_holdoff #(
  parameter int HOLD_CYCLES = 8,
  parameter int HW = $clog2(HOLD_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic retry,
  output logic hold
);
  localparam logic [HW-1:0] HLOAD = HW'(HOLD_CYCLES);
  logic [HW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                  cnt <= '0;
    else if (retry && enable) cnt <= HLOAD;
    else if (cnt != '0)       cnt <= cnt - 1'b1;
  end

  assign hold = (cnt != '0);

  AST_HOLD_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (retry && enable) |=> (cnt == HLOAD)); // R10
  AST_HOLD_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!enable && cnt == '0) |=> (cnt == '0)); // R10
endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
  parameter int N_EXT = 4,
  parameter int DM_W  = 3,
  parameter int OW    = 3,
  parameter int IW    = $clog2(N_EXT)
) (
  input  logic [N_EXT-1:0] req_ext,
  input  logic             req_host,
  input  logic [N_EXT-1:0] en,
  input  logic             blk,
  input  logic [IW-1:0]    rr_last,
  input  logic             park_en,
  input  arb_pkg::park_mode_e park_mode,
  input  logic [DM_W-1:0]  dflt,
  input  logic [OW-1:0]    last_own,
  output logic [OW-1:0]    nxt,
  output logic             from_req
);
  localparam logic [OW-1:0] HOST = OW'(N_EXT);
  localparam logic [OW-1:0] NONE = OW'(N_EXT + 1);

  logic [N_EXT-1:0] elig;
  logic             rr_found;
  logic [OW-1:0]    rr_pick;
  logic [OW-1:0]    cand;

  assign elig = req_ext & en & {N_EXT{!blk}};

  always_comb begin
    rr_found = 1'b0;
    rr_pick  = '0;
    for (int k = 1; k <= N_EXT; k++) begin
      if (!rr_found && elig[(int'(rr_last) + k) % N_EXT]) begin
        rr_found = 1'b1;
        rr_pick  = OW'((int'(rr_last) + k) % N_EXT);
      end
    end
  end

  always_comb begin
    cand     = (park_mode == arb_pkg::PARK_DFLT) ? OW'(dflt) : last_own;
    from_req = 1'b0;
    if (req_host) begin
      nxt = HOST;
    end else if (rr_found) begin
      nxt      = rr_pick;
      from_req = 1'b1;
    end else if (park_en) begin
      if (cand == HOST)
        nxt = HOST;
      else if (int'(cand) < N_EXT && en[cand[IW-1:0]] && !blk)
        nxt = cand;
      else
        nxt = NONE;
    end else begin
      nxt = NONE;
    end
  end
endmodule

// File: rtl/bus_grant_arbiter.sv
module bus_grant_arbiter #(
  parameter int N_EXT       = 4,
  parameter int HOLD_CYCLES = 8,
  parameter int PEND_W      = 3,
  localparam int DM_W  = $clog2(N_EXT + 1),
  localparam int CFG_W = N_EXT + 4 + DM_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic [N_EXT-1:0] req_ext,
  input  logic             req_host,
  input  logic             addr_start,
  input  logic             addr_end,
  input  logic             data_end,
  input  logic             addr_retry,
  output logic [N_EXT-1:0] gnt_ext,
  output logic             gnt_host
);
  localparam int OW = arb_pkg::owner_width(N_EXT);
  localparam int IW = $clog2(N_EXT);
  localparam int B_PARK = N_EXT;
  localparam int B_MODE = N_EXT + 1;
  localparam int B_DFLT = N_EXT + 2;
  localparam int B_PIPE = N_EXT + 2 + DM_W;
  localparam int B_HOLD = N_EXT + 3 + DM_W;
  localparam logic [OW-1:0] HOST = OW'(N_EXT);
  localparam logic [OW-1:0] NONE = OW'(N_EXT + 1);

  logic [CFG_W-1:0] cfg;
  logic abusy, pend_ok, hold, blk, from_req;
  logic [OW-1:0] nxt, last_own;
  logic [IW-1:0] rr_last;
  arb_pkg::park_mode_e pmode;

  arb_cfg_reg #(.N_EXT(N_EXT), .DM_W(DM_W), .CFG_W(CFG_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .q(cfg));

  arb_tenure #(.PEND_W(PEND_W)) u_ten (
    .clk(clk), .rst(rst), .addr_start(addr_start), .addr_end(addr_end),
    .data_end(data_end), .abusy(abusy), .pend_ok(pend_ok));

  arb_holdoff #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk(clk), .rst(rst), .enable(cfg[B_HOLD]), .retry(addr_retry), .hold(hold));

  assign blk   = hold | (cfg[B_PIPE] & !pend_ok);
  assign pmode = arb_pkg::park_mode_e'(cfg[B_MODE]);

  arb_pick #(.N_EXT(N_EXT), .DM_W(DM_W), .OW(OW), .IW(IW)) u_pick (
    .req_ext(req_ext), .req_host(req_host), .en(cfg[N_EXT-1:0]), .blk(blk),
    .rr_last(rr_last), .park_en(cfg[B_PARK]), .park_mode(pmode),
    .dflt(cfg[B_DFLT +: DM_W]), .last_own(last_own), .nxt(nxt), .from_req(from_req));

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_ext  <= '0;
      gnt_host <= 1'b0;
      rr_last  <= IW'(N_EXT - 1);
      last_own <= HOST;
    end else if (!abusy) begin
      for (int i = 0; i < N_EXT; i++) gnt_ext[i] <= (nxt == OW'(i));
      gnt_host <= (nxt == HOST);
      if (nxt != NONE) last_own <= nxt;
      if (from_req)    rr_last  <= nxt[IW-1:0];
    end
  end

  assign cfg_rdata = cfg;

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (rst)
    $onehot0({gnt_ext, gnt_host})); // R11
  AST_FREEZE_IN_TENURE: assert property (@(posedge clk) disable iff (rst)
    abusy |=> $stable({gnt_ext, gnt_host})); // R11
  AST_NEW_EXT_ENABLED: assert property (@(posedge clk) disable iff (rst)
    !(|(gnt_ext & ~$past(gnt_ext) & ~$past(cfg[N_EXT-1:0])))); // R5
  AST_NEW_EXT_NOT_HELD: assert property (@(posedge clk) disable iff (rst)
    (|(gnt_ext & ~$past(gnt_ext))) |-> !$past(hold)); // R10
  AST_NEW_EXT_DEPTH: assert property (@(posedge clk) disable iff (rst)
    (|(gnt_ext & ~$past(gnt_ext))) |-> !($past(cfg[B_PIPE]) && !$past(pend_ok))); // R9
  AST_HOST_FIRST: assert property (@(posedge clk) disable iff (rst)
    ($past(req_host) && !$past(abusy) && !$past(rst)) |-> gnt_host); // R3
  AST_NO_PARK_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(req_host) && $past(req_ext) == '0 && !$past(cfg[B_PARK]) &&
     !$past(abusy) && !$past(rst)) |-> ({gnt_ext, gnt_host} == '0)); // R6
endmodule

// File: tb/tb_bus_grant_arbiter.sv
module tb_bus_grant_arbiter;
  localparam int N = 4, CW = 11, HOSTV = 4, NONEV = 5, PMAX = 7, HOLD = 8;

  logic clk = 1'b0, rst = 1'b1;
  always #4 clk = ~clk;

  logic cfg_we = 0, req_host = 0, addr_start = 0, addr_end = 0, data_end = 0, addr_retry = 0;
  logic [CW-1:0] cfg_wdata = '0, cfg_rdata;
  logic [N-1:0] req_ext = '0, gnt_ext;
  logic gnt_host;

  bus_grant_arbiter dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_ext(req_ext), .req_host(req_host), .addr_start(addr_start), .addr_end(addr_end),
    .data_end(data_end), .addr_retry(addr_retry), .gnt_ext(gnt_ext), .gnt_host(gnt_host));

  int n_chk = 0, n_fail = 0;
  logic [CW-1:0] m_cfg = 11'h40F;
  int m_rr = N - 1, m_last = HOSTV, m_pend = 0, m_hcnt = 0, m_own = NONEV;
  bit m_abusy = 0;

  function automatic int own_of();
    int o = NONEV, c = 0;
    if (gnt_host) begin o = HOSTV; c++; end
    for (int i = 0; i < N; i++) if (gnt_ext[i]) begin o = i; c++; end
    return (c > 1) ? -1 : o;
  endfunction

  function automatic void m_pick(output int o, output bit fr);
    bit blk = (m_hcnt != 0) || (m_cfg[9] && m_pend > 1);
    int cand;
    o = NONEV; fr = 0;
    if (req_host) begin o = HOSTV; return; end
    for (int k = 1; k <= N; k++) begin
      int idx = (m_rr + k) % N;
      if (req_ext[idx] && m_cfg[idx] && !blk) begin o = idx; fr = 1; return; end
    end
    if (m_cfg[4]) begin
      cand = m_cfg[5] ? int'(m_cfg[8:6]) : m_last;
      if (cand == HOSTV) o = HOSTV;
      else if (cand < N && m_cfg[cand] && !blk) o = cand;
    end
  endfunction

  task automatic step(input string tag);
    int p; bit fr;
    logic [CW-1:0] n_cfg = cfg_we ? cfg_wdata : m_cfg;
    int n_pend = m_pend, n_hcnt = m_hcnt;
    bit n_abusy = addr_start ? 1 : (addr_end ? 0 : m_abusy);
    m_pick(p, fr);
    if (addr_start && !data_end && m_pend < PMAX) n_pend++;
    if (data_end && !addr_start && m_pend > 0) n_pend--;
    if (addr_retry && m_cfg[10]) n_hcnt = HOLD; else if (m_hcnt > 0) n_hcnt--;
    if (!m_abusy) begin
      m_own = p;
      if (p != NONEV) m_last = p;
      if (fr) m_rr = p;
    end
    @(posedge clk);
    m_cfg = n_cfg; m_pend = n_pend; m_hcnt = n_hcnt; m_abusy = n_abusy;
    #1;
    cfg_we = 0; addr_start = 0; addr_end = 0; data_end = 0; addr_retry = 0;
    n_chk++;
    if (own_of() != m_own || cfg_rdata !== m_cfg) begin
      n_fail++;
      $display("FAIL %s: owner=%0d cfg=%h expected owner=%0d cfg=%h", tag, own_of(), cfg_rdata, m_own, m_cfg);
    end
  endtask

  task automatic lit(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wcfg(input logic [CW-1:0] v, input string tag);
    cfg_wdata = v; cfg_we = 1; step(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    #1 rst = 0;
    lit("R1 reset cfg", int'(cfg_rdata), 'h40F);
    lit("R1 reset grant", own_of(), NONEV);

    // R4 rotation from index 0
    req_ext = 4'hF;
    for (int i = 0; i < 4; i++) begin step("R4"); lit("R4 order", own_of(), i); end
    // R3 host wins
    req_host = 1; step("R3"); lit("R3 host", own_of(), HOSTV); req_host = 0;
    // R2 and R5
    wcfg(11'h40A, "R2"); lit("R2 readback", int'(cfg_rdata), 'h40A);
    for (int i = 0; i < 4; i++) begin step("R5"); lit("R5 disabled", int'(gnt_ext & 4'b0101), 0); end
    // R6
    req_ext = '0; step("R6"); lit("R6 idle", own_of(), NONEV);
    // R7 park last
    wcfg(11'h41F, "R7"); req_ext = 4'b0100; step("R7"); req_ext = '0;
    step("R7"); step("R7"); lit("R7 park last", own_of(), 2);
    // R8 park default
    wcfg(11'h53F, "R8"); step("R8"); lit("R8 dflt host", own_of(), HOSTV);
    wcfg(11'h47F, "R8"); step("R8"); lit("R8 dflt ext", own_of(), 1);
    wcfg(11'h5BF, "R8"); step("R8"); lit("R8 dflt invalid", own_of(), NONEV);
    // R9 pipeline depth
    wcfg(11'h60F, "R9");
    addr_start = 1; step("R9"); addr_end = 1; step("R9");
    addr_start = 1; step("R9"); addr_end = 1; step("R9");
    req_ext = 4'b0001; step("R9"); step("R9"); lit("R9 blocked", own_of(), NONEV);
    req_host = 1; step("R9"); lit("R9 host ok", own_of(), HOSTV); req_host = 0;
    data_end = 1; step("R9"); lit("R9 still", own_of(), NONEV);
    step("R9"); lit("R9 freed", own_of(), 0);
    data_end = 1; step("R9");
    wcfg(11'h40F, "R10");
    // R10 hold-off window
    req_ext = '0; step("R10");
    addr_retry = 1; step("R10"); req_ext = 4'b0010;
    for (int i = 0; i < HOLD; i++) begin step("R10"); lit("R10 held", own_of(), NONEV); end
    step("R10"); lit("R10 release", own_of(), 1);
    req_ext = '0; step("R10"); addr_retry = 1; step("R10"); req_ext = 4'b0010;
    for (int i = 0; i < 4; i++) step("R10");
    addr_retry = 1; step("R10");
    for (int i = 0; i < HOLD; i++) begin step("R10"); lit("R10 restart", own_of(), NONEV); end
    req_host = 1; step("R10"); lit("R10 host", own_of(), HOSTV); req_host = 0;
    step("R10"); lit("R10 after", own_of(), 1);
    wcfg(11'h00F, "R10"); req_ext = '0; step("R10");
    addr_retry = 1; step("R10"); req_ext = 4'b0010; step("R10");
    lit("R10 mode off", own_of(), 1);
    // R11 freeze during address tenure
    wcfg(11'h40F, "R11"); req_ext = 4'b0001; step("R11"); step("R11");
    addr_start = 1; step("R11"); req_ext = 4'b0010;
    for (int i = 0; i < 3; i++) begin step("R11"); lit("R11 frozen", own_of(), 0); end
    addr_end = 1; step("R11"); lit("R11 end cycle", own_of(), 0);
    step("R11"); lit("R11 moved", own_of(), 1);
    data_end = 1; step("R11");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      req_ext  = N'($urandom);
      req_host = ($urandom % 8 == 0);
      addr_start = !m_abusy && m_pend < 6 && ($urandom % 4 == 0);
      addr_end   = m_abusy && ($urandom % 3 == 0);
      data_end   = m_pend > 0 && ($urandom % 3 == 0);
      addr_retry = ($urandom % 20 == 0);
      if ($urandom % 50 == 0) begin cfg_we = 1; cfg_wdata = CW'($urandom); end
      step("R11 random");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule